// File: doc/BRIEF.md
# PCI Address Parity Guard

This block watches the address phase of a PCI-style target interface and decides how the target responds when the address parity is wrong. It latches the address/data lines, the command/byte-enable lines and a decoded address-hit flag on the clock that first sees FRAME# asserted. On the next clock it samples PAR and checks even parity over all of them. Any bus command is checked.

Two command-register controls, parity-error response and system-error enable, set what happens next. With parity-error response enabled, a bad address stops the target from claiming the cycle, so the initiator ends in a master abort. With it disabled, the target claims on a hit as usual. A detected-parity-error status bit records every bad address. A system-error pulse, and a status bit that records it, are produced only when both controls are on. Software clears each status bit by writing 1 to it. A parameter selects when DEVSEL# is first asserted. In fast timing the parity result feeds DEVSEL# on the same clock that samples PAR. In medium timing the result is registered first and the claim comes one clock later.

Top module: `pci_addr_parity_guard`

## Requirements
- R1: The address phase is the first rising clock edge that samples `frame_n` low after a sample of `frame_n` high. The rising edge after it samples `par`. An address parity error is flagged when the XOR of the captured `ad`, the captured `cbe_n` and the sampled `par` is 1, whatever the command value.
- R2: If an address parity error is flagged and `cfg_perr_resp` is 1, `devsel_n` stays high for that transaction.
- R3: If `cfg_perr_resp` is 0, a parity error does not affect claiming. The target claims exactly when `tgt_hit` was 1 in the address phase, and never claims when it was 0.
- R4: `stat_dpe` is set by every address parity error, whatever the two command controls are.
- R5: `serr_n` goes low for exactly one clock, and `stat_sse` is set, only for an address parity error with both `cfg_perr_resp` and `cfg_serr_en` at 1. `serr_n` goes low on the edge that samples `par`.
- R6: The status bits are sticky. A clock with `sts_wr` 1 clears `stat_dpe` when `sts_wdata[0]` is 1 and clears `stat_sse` when `sts_wdata[1]` is 1. A 0 in a bit position changes nothing. A new error in the same clock as a clear leaves the bit set.
- R7: With `FAST_CLAIM`=1, a claim drives `devsel_n` low from the edge that samples `par`. With `FAST_CLAIM`=0, it drives `devsel_n` low one edge later.
- R8: Once claimed, `devsel_n` returns high at the first rising edge that samples `frame_n` high.
- R9: A clock edge with `rst_n` low clears both status bits and drives `serr_n` and `devsel_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Cycle framing, active low |
| ad | input | AD_W | Address/data lines |
| cbe_n | input | AD_W/8 | Command/byte-enable lines |
| par | input | 1 | Even parity over ad and cbe_n, valid one clock after them |
| tgt_hit | input | 1 | Address decode says this target is addressed |
| cfg_perr_resp | input | 1 | Command control: respond to parity errors |
| cfg_serr_en | input | 1 | Command control: allow system-error signalling |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 2 | Write-1-to-clear mask: bit 0 detected parity error, bit 1 signaled system error |
| devsel_n | output | 1 | Target claim, active low |
| serr_n | output | 1 | System-error pulse, active low |
| stat_dpe | output | 1 | Detected-parity-error status |
| stat_sse | output | 1 | Signaled-system-error status |

## Verification
The assertions check on every cycle that a parity check lasts one clock, that a system-error pulse is one clock long, and that the pulse only follows a clock with both controls on. They also check that a parity error with response enabled never produces a claim in the selected timing, and that a status bit holds unless a clear is written to it. The bench scenarios cover the rest. They use good and bad parity under several command patterns, with and without an address hit. They show the claim timing of both timing variants side by side, the sticky and clear behaviour, a clear in the same clock as a new error, and the reset state.

// File: rtl/apar_pkg.sv
// Package: shared status-bit positions and types for the address parity guard.
// Assumes: software writes a 2-bit clear mask whose bit positions match these.
package apar_pkg;
    localparam int STS_W   = 2;
    localparam int STS_DPE = 0;  // detected parity error
    localparam int STS_SSE = 1;  // signaled system error
    typedef logic [STS_W-1:0] sts_t;
endpackage

// File: rtl/apar_check.sv
// Module: apar_check
// Finds the address phase, latches address, command and hit, then on the next
// clock checks even parity against PAR. chk_now is high during the clock
// whose closing edge samples PAR.
// Assumes: FRAME# is deasserted for at least one clock between transactions.
module apar_check #(
    parameter int AD_W  = 32,
    parameter int CBE_W = AD_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe_n,
    input  logic             par,
    input  logic             tgt_hit,
    output logic             chk_now,
    output logic             par_err,
    output logic             hit_q
);
    logic             frame_q;
    logic             addr_phase;
    logic [AD_W-1:0]  ad_q;
    logic [CBE_W-1:0] cbe_q;

    // Purpose: flag the first clock with FRAME# newly asserted.
    assign addr_phase = frame_q && !frame_n;

    // Purpose: remember FRAME# and mark the clock that follows an address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= 1'b1;
            chk_now <= 1'b0;
        end else begin
            frame_q <= frame_n;
            chk_now <= addr_phase;
        end
    end

    // Purpose: hold the address-phase lines until PAR arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ad_q  <= '0;
            cbe_q <= '0;
            hit_q <= 1'b0;
        end else if (addr_phase) begin
            ad_q  <= ad;
            cbe_q <= cbe_n;
            hit_q <= tgt_hit;
        end
    end

    // Purpose: even parity check over address, command and PAR.
    assign par_err = chk_now && (^{ad_q, cbe_q, par});

    // R1: a parity check spans exactly one clock per address phase
    p_chk_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        chk_now |=> !chk_now);
endmodule

// File: rtl/apar_claim.sv
// Module: apar_claim
// Drives DEVSEL# for a decoded hit unless an address parity error must
// suppress the claim. FAST_CLAIM picks fast timing (decision taken from PAR
// on the edge that samples it) or medium timing (decision registered first).
// Assumes: hit decode is already latched at the address phase.
module apar_claim #(
    parameter bit FAST_CLAIM = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic chk_now,
    input  logic par_err,
    input  logic hit_q,
    input  logic cfg_perr_resp,
    output logic devsel_n
);
    logic claim_ok;
    logic claim_go;

    // Purpose: claim on a hit unless parity response vetoes it.
    assign claim_ok = chk_now && hit_q && !(par_err && cfg_perr_resp);

    generate
        if (FAST_CLAIM) begin : g_fast
            // Purpose: fast slot uses the decision directly.
            assign claim_go = claim_ok;

            // R2: suppressed claim never drives DEVSEL# in fast timing
            p_no_claim_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (chk_now && par_err && cfg_perr_resp) |=> devsel_n);
        end else begin : g_medium
            logic claim_q;
            // Purpose: medium slot waits one clock for a registered decision.
            always_ff @(posedge clk) begin
                if (!rst_n) claim_q <= 1'b0;
                else        claim_q <= claim_ok;
            end
            assign claim_go = claim_q;

            // R2: suppressed claim never drives DEVSEL# in medium timing
            p_no_claim_med_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (chk_now && par_err && cfg_perr_resp) |=> ##1 devsel_n);
        end
    endgenerate

    // Purpose: assert DEVSEL# on a claim, release it once FRAME# is seen high.
    always_ff @(posedge clk) begin
        if (!rst_n)                   devsel_n <= 1'b1;
        else if (claim_go)            devsel_n <= 1'b0;
        else if (!devsel_n && frame_n) devsel_n <= 1'b1;
    end

    // R8: a held claim is released after FRAME# is sampled high
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!devsel_n && frame_n && !claim_go) |=> devsel_n);
endmodule

// File: rtl/apar_status.sv
// Module: apar_status
// Keeps the sticky write-1-to-clear status bits and produces the one-clock
// SERR# pulse. Setting wins over clearing in the same clock.
// Assumes: par_err is valid only in the clock that samples PAR.
module apar_status
    import apar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic par_err,
    input  logic cfg_perr_resp,
    input  logic cfg_serr_en,
    input  logic sts_wr,
    input  sts_t sts_wdata,
    output logic serr_n,
    output sts_t sts
);
    sts_t set_v;
    sts_t clr_v;

    // Purpose: work out which bits to set and which to clear this clock.
    always_comb begin
        set_v          = '0;
        set_v[STS_DPE] = par_err;
        set_v[STS_SSE] = par_err && cfg_perr_resp && cfg_serr_en;
        clr_v          = sts_wr ? sts_wdata : '0;
    end

    // Purpose: sticky status with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= '0;
        else        sts <= set_v | (sts & ~clr_v);
    end

    // Purpose: one-clock active-low system-error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) serr_n <= 1'b1;
        else        serr_n <= !set_v[STS_SSE];
    end

    // R5: system-error pulse lasts one clock
    p_serr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |=> serr_n);
    // R5: pulse only follows a clock with both controls enabled
    p_serr_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past(cfg_perr_resp && cfg_serr_en));
    // R5: signaled-system-error is never set without detected-parity-error
    p_sse_with_dpe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[STS_SSE]) |-> sts[STS_DPE]);
    // R6: detected-parity-error holds unless a clear is written
    p_dpe_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[STS_DPE] && !(sts_wr && sts_wdata[STS_DPE])) |=> sts[STS_DPE]);
endmodule

// File: rtl/pci_addr_parity_guard.sv
// Module: pci_addr_parity_guard (top)
// Address-phase parity checking for a PCI-style target: parity check, claim
// suppression, system-error pulse and write-1-to-clear status bits.
// Assumes: address decode happens outside and arrives on tgt_hit during the
// address phase; data-phase parity is handled elsewhere.
module pci_addr_parity_guard
    import apar_pkg::*;
#(
    parameter int AD_W       = 32,
    parameter bit FAST_CLAIM = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [AD_W-1:0]   ad,
    input  logic [AD_W/8-1:0] cbe_n,
    input  logic              par,
    input  logic              tgt_hit,
    input  logic              cfg_perr_resp,
    input  logic              cfg_serr_en,
    input  logic              sts_wr,
    input  logic [1:0]        sts_wdata,
    output logic              devsel_n,
    output logic              serr_n,
    output logic              stat_dpe,
    output logic              stat_sse
);
    localparam int CBE_W = AD_W / 8;

    logic chk_now;
    logic par_err;
    logic hit_q;
    sts_t sts;

    apar_check #(.AD_W(AD_W), .CBE_W(CBE_W)) u_check (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n),
        .ad      (ad),
        .cbe_n   (cbe_n),
        .par     (par),
        .tgt_hit (tgt_hit),
        .chk_now (chk_now),
        .par_err (par_err),
        .hit_q   (hit_q)
    );

    apar_claim #(.FAST_CLAIM(FAST_CLAIM)) u_claim (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_n       (frame_n),
        .chk_now       (chk_now),
        .par_err       (par_err),
        .hit_q         (hit_q),
        .cfg_perr_resp (cfg_perr_resp),
        .devsel_n      (devsel_n)
    );

    apar_status u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .par_err       (par_err),
        .cfg_perr_resp (cfg_perr_resp),
        .cfg_serr_en   (cfg_serr_en),
        .sts_wr        (sts_wr),
        .sts_wdata     (sts_wdata),
        .serr_n        (serr_n),
        .sts           (sts)
    );

    // Purpose: bring the status bits out by name.
    assign stat_dpe = sts[STS_DPE];
    assign stat_sse = sts[STS_SSE];

    // R9: status bits are clear in the clock after reset
    p_reset_clear_r9: assert property (@(posedge clk)
        $past(!rst_n) |-> (!stat_dpe && !stat_sse && serr_n && devsel_n));
endmodule

// File: tb/test_pci_addr_parity_guard.sv
// Directed bench: one task per scenario; inputs driven and outputs sampled on
// the falling edge. A second instance runs the medium claim timing.
module test_pci_addr_parity_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = '0;
    logic        par = 1'b0;
    logic        tgt_hit = 1'b0;
    logic        cfg_perr_resp = 1'b0;
    logic        cfg_serr_en = 1'b0;
    logic        sts_wr = 1'b0;
    logic [1:0]  sts_wdata = '0;
    logic        devsel_n, serr_n, stat_dpe, stat_sse;
    logic        devsel_m_n, serr_m_n, stat_m_dpe, stat_m_sse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic exp_dpe = 1'b0;
    logic exp_sse = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    pci_addr_parity_guard #(.AD_W(32), .FAST_CLAIM(1'b1)) i_pci_addr_parity_guard (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ad(ad), .cbe_n(cbe_n),
        .par(par), .tgt_hit(tgt_hit), .cfg_perr_resp(cfg_perr_resp),
        .cfg_serr_en(cfg_serr_en), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .devsel_n(devsel_n), .serr_n(serr_n), .stat_dpe(stat_dpe), .stat_sse(stat_sse)
    );

    pci_addr_parity_guard #(.AD_W(32), .FAST_CLAIM(1'b0)) i_pci_addr_parity_guard_med (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ad(ad), .cbe_n(cbe_n),
        .par(par), .tgt_hit(tgt_hit), .cfg_perr_resp(cfg_perr_resp),
        .cfg_serr_en(cfg_serr_en), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .devsel_n(devsel_m_n), .serr_n(serr_m_n), .stat_dpe(stat_m_dpe), .stat_sse(stat_m_sse)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic chk_status(input string req);
        chk(req, "stat_dpe", stat_dpe, exp_dpe);
        chk(req, "stat_sse", stat_sse, exp_sse);
    endtask

    // One transaction: address phase, PAR clock, two data clocks, end.
    task automatic run_txn(input string req, input logic [31:0] a, input logic [3:0] c,
                           input logic hit, input logic bad, input logic per,
                           input logic se, input logic clr_at_check);
        logic claim, pulse;
        claim = hit && !(bad && per);
        pulse = bad && per && se;
        @(negedge clk);
        frame_n = 1'b0; ad = a; cbe_n = c; tgt_hit = hit;
        cfg_perr_resp = per; cfg_serr_en = se;
        @(negedge clk);                       // after address-phase edge
        par = (^{a, c}) ^ bad;
        ad = ~a; tgt_hit = ~hit;              // data phase, hit no longer valid
        if (clr_at_check) begin sts_wr = 1'b1; sts_wdata = 2'b11; end
        chk(req, "devsel_n before check", devsel_n, 1'b1);
        @(negedge clk);                       // after edge sampling PAR
        sts_wr = 1'b0; sts_wdata = 2'b00;
        if (clr_at_check) begin exp_dpe = 1'b0; exp_sse = 1'b0; end
        exp_dpe = exp_dpe | bad;
        exp_sse = exp_sse | pulse;
        chk(req, "serr_n at check", serr_n, !pulse);
        chk(req, "devsel_n fast slot", devsel_n, !claim);
        chk(req, "devsel_n medium before slot", devsel_m_n, 1'b1);
        chk_status(req);
        @(negedge clk);
        chk(req, "serr_n after pulse", serr_n, 1'b1);
        chk(req, "devsel_n fast held", devsel_n, !claim);
        chk(req, "devsel_n medium slot", devsel_m_n, !claim);
        frame_n = 1'b1;
        @(negedge clk);                       // edge sampled FRAME# high
        chk(req, "devsel_n fast released", devsel_n, 1'b1);
        chk(req, "devsel_n medium released", devsel_m_n, 1'b1);
        chk(req, "medium serr_n matches", serr_m_n, 1'b1);
        chk(req, "medium stat_dpe matches", stat_m_dpe, exp_dpe);
        chk(req, "medium stat_sse matches", stat_m_sse, exp_sse);
    endtask

    task automatic write_clear(input string req, input logic [1:0] mask);
        @(negedge clk);
        sts_wr = 1'b1; sts_wdata = mask;
        @(negedge clk);
        sts_wr = 1'b0; sts_wdata = 2'b00;
        if (mask[0]) exp_dpe = 1'b0;
        if (mask[1]) exp_sse = 1'b0;
        chk_status(req);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R9", "devsel_n in reset", devsel_n, 1'b1);
        chk("R9", "serr_n in reset", serr_n, 1'b1);
        chk_status("R9");
        rst_n = 1'b1;
    endtask

    task automatic t_good_parity();
        // R1 R3: good parity, several commands, hit and miss
        run_txn("R1", 32'h1234_5678, 4'h6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        run_txn("R3", 32'hFFFF_0000, 4'hB, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        run_txn("R7", 32'h0000_0001, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_bad_parity();
        // R2: error with response on suppresses the claim, no pulse (serr off)
        run_txn("R2", 32'hA5A5_A5A5, 4'h7, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        // R4: detected bit set even with both controls off; claim kept (R3)
        write_clear("R6", 2'b01);
        run_txn("R4", 32'h8000_0000, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        // R5: serr enable alone does not pulse
        run_txn("R5", 32'h0F0F_0F0F, 4'h2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        // R5: both on pulses and sets signaled bit
        run_txn("R5", 32'hDEAD_BEEF, 4'hA, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_status_clear();
        // R6: zero mask is ignored, then clear one bit at a time
        write_clear("R6", 2'b00);
        write_clear("R6", 2'b10);
        write_clear("R6", 2'b01);
        // R6: clear in the same clock as a new error keeps both set
        run_txn("R6", 32'h1357_9BDF, 4'hC, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        // R6: clear with good parity empties them
        run_txn("R6", 32'h2468_ACE0, 4'h3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_reset_again();
        run_txn("R9", 32'h7777_0000, 4'h1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        exp_dpe = 1'b0; exp_sse = 1'b0;
        chk_status("R9");
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_good_parity();
        t_bad_parity();
        t_status_clear();
        t_reset_again();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule